// File: doc/BRIEF.md
# Credit-based interrupt moderator

This block sits between the descriptor rings of a switch and its interrupt vectors and decides when a ring's completion activity turns into an interrupt request. Each ring keeps a count of descriptors that hardware has finished and that the driver has not yet acknowledged. It also keeps a moderation mask that is set automatically when the ring raises an interrupt. The first completion on an idle ring raises one interrupt and sets that mask. Later completions only add to the count. The driver acknowledges work by writing a number of returned credits for a ring. If the count reaches zero, the ring re-arms without interrupting. If work remains, the ring raises one more interrupt and stays masked.

Ring interrupts map onto vectors as follows. Ring 0 uses vector 0 and ring 1 uses vector 1. Vectors 2 and 3 are never used by rings. Ring r (r ≥ 2) uses vector r + 2, which gives transmit rings even vectors and receive rings odd vectors. A separate per-vector mask input, driven from the vector table's control bit, holds an interrupt back as a pending bit until the vector is unmasked. When several vectors are ready, they go out one per cycle, lowest number first. Building the message and writing it to the bus are left to the logic downstream.

Top module: `credit_irq_moderator`

## Requirements
- R1: Each completion strobe on a ring raises that ring's credit count by one. The count saturates at its maximum (2^CREDIT_W − 1). The count is readable at any time through the read port.
- R2: A completion on a ring whose moderation mask is clear raises exactly one interrupt on that ring's vector and sets the moderation mask.
- R3: Completions that arrive while the moderation mask is set raise only the count and produce no interrupt.
- R4: A credit return that brings the count to zero clears the moderation mask and produces no interrupt. The next completion on that ring interrupts again.
- R5: A credit return that leaves a non-zero count produces exactly one interrupt on the ring's vector and keeps the moderation mask set.
- R6: A return larger than the outstanding count sets the count to zero and behaves as a full return.
- R7: A completion and a return on the same ring in the same cycle both take effect. The new count is old + 1 − returned, clamped at zero. An interrupt is raised only if the result is non-zero.
- R8: Ring 0 maps to vector 0, ring 1 to vector 1, and ring r ≥ 2 to vector r + 2. Vectors 2 and 3 are never requested or pending.
- R9: An interrupt for a vector whose mask input is 1 sets that vector's pending bit and is not delivered. When the mask input returns to 0, the vector is delivered and its pending bit clears.
- R10: The per-vector mask input does not change any ring's count or moderation mask. Completions during a vector mask are counted normally.
- R11: When more than one vector is ready, one request is issued per cycle, lowest vector number first.
- R12: After reset, all counts are zero, no pending bits are set and no request is issued. An interrupt caused at clock edge k shows as a pending bit after edge k and as a one-cycle request after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_i | input | NUM_RINGS | Per-ring completion strobe, one descriptor per cycle |
| ret_we_i | input | 1 | Credit-return write strobe |
| ret_ring_i | input | RING_W | Ring addressed by the credit-return write |
| ret_cnt_i | input | CREDIT_W | Number of credits returned |
| rd_ring_i | input | RING_W | Ring selected for count read-back |
| rd_credit_o | output | CREDIT_W | Outstanding count of the selected ring |
| vec_mask_i | input | NUM_VEC | Per-vector mask bit, 1 = masked |
| irq_valid_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | VEC_W | Vector number of the request |
| pending_o | output | NUM_VEC | Per-vector pending bits |

## Verification
A completion strobe and a credit-return write can land on the same ring in the same clock. The count update and the decision to re-interrupt must then treat both together. The bench provokes this by driving both inputs in one cycle with returns smaller than, equal to, and larger than old + 1. It judges the result by the count read back and by whether a request for the ring's vector reaches the scoreboard. Two vectors becoming ready in the same cycle after a shared unmask is the second collision; the scoreboard demands their requests in ascending order.

// File: rtl/imod_pkg.sv
// Package: shared helpers for the credit-based interrupt moderator.
// Assumes ring indices are non-negative and vectors 2 and 3 are kept off ring use.
package imod_pkg;

    // Vector used by a given ring: rings 0/1 map straight, later rings skip two slots.
    function automatic int ring_to_vec(input int ring);
        return (ring < 2) ? ring : ring + 2;
    endfunction

endpackage

// File: rtl/imod_ring_credit.sv
// Module: one ring's credit counter and moderation mask.
// Counts completed descriptors, applies credit returns (clamped at zero,
// saturated at the top), and raises a one-cycle fire pulse when the ring
// must interrupt. Assumes at most one completion per cycle.
module imod_ring_credit #(
    parameter int CREDIT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmpl_i,
    input  logic                ret_we_i,
    input  logic [CREDIT_W-1:0] ret_cnt_i,
    output logic [CREDIT_W-1:0] credit_o,
    output logic                automask_o,
    output logic                fire_o
);
    localparam int SW = CREDIT_W + 1;
    localparam logic [CREDIT_W-1:0] MAXC = '1;
    localparam logic [SW-1:0] MAXW = {1'b0, MAXC};

    logic [CREDIT_W-1:0] cnt_q;
    logic                amask_q;
    logic [SW-1:0]       sum_w;
    logic [SW-1:0]       ret_w;
    logic [SW-1:0]       left_w;
    logic [CREDIT_W-1:0] cnt_next;
    logic                amask_next;

    // Next count: old plus completion minus return, clamped to [0, MAX].
    always_comb begin
        sum_w    = {1'b0, cnt_q} + SW'(cmpl_i);
        ret_w    = ret_we_i ? {1'b0, ret_cnt_i} : '0;
        left_w   = (sum_w > ret_w) ? (sum_w - ret_w) : '0;
        cnt_next = (left_w > MAXW) ? MAXC : left_w[CREDIT_W-1:0];
    end

    // Fire and mask decision: a return re-evaluates, otherwise first completion fires.
    always_comb begin
        if (ret_we_i) begin
            fire_o     = (cnt_next != '0);
            amask_next = (cnt_next != '0);
        end else begin
            fire_o     = cmpl_i && !amask_q;
            amask_next = amask_q || cmpl_i;
        end
    end

    // State registers for count and moderation mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            amask_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_next;
            amask_q <= amask_next;
        end
    end

    assign credit_o   = cnt_q;
    assign automask_o = amask_q;

    // An unmasked ring never holds outstanding credits.
    p_idle_is_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !amask_q |-> (cnt_q == '0));

    // Firing always leaves the ring masked.
    p_fire_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> amask_q);

    // A lone completion below the ceiling adds exactly one.
    p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && !ret_we_i && cnt_q != MAXC) |=> (cnt_q == $past(cnt_q) + CREDIT_W'(1)));

    // A return covering everything outstanding empties and re-arms the ring.
    p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_we_i && ({1'b0, ret_cnt_i} >= ({1'b0, cnt_q} + SW'(cmpl_i))))
        |=> (cnt_q == '0 && !amask_q));

    // Masked completions without a return never fire.
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (amask_q && !ret_we_i) |-> !fire_o);

endmodule

// File: rtl/imod_pick_first.sv
// Module: find-first-set selector.
// Returns a one-hot grant for the lowest set request bit and its index.
// Pure combinational; assumes N >= 2.
module imod_pick_first #(
    parameter  int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Scan from bit 0 upward and keep the first hit.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
                any_o      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/imod_vec_dispatch.sv
// Module: per-vector pending bits and request issue.
// Latches fire events per vector, holds them while the vector mask is set,
// and issues one registered request per cycle, lowest vector first.
// A new event in the cycle a vector is served keeps it pending.
module imod_vec_dispatch #(
    parameter  int NUM_VEC = 10,
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] fire_vec_i,
    input  logic [NUM_VEC-1:0] vec_mask_i,
    output logic [NUM_VEC-1:0] pending_o,
    output logic               irq_valid_o,
    output logic [VEC_W-1:0]   irq_vec_o
);
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] ready_w;
    logic [NUM_VEC-1:0] grant_w;
    logic [VEC_W-1:0]   idx_w;
    logic               any_w;
    logic               valid_q;
    logic [VEC_W-1:0]   vec_q;

    // Vectors that may go out this cycle.
    assign ready_w = pend_q & ~vec_mask_i;

    imod_pick_first #(.N(NUM_VEC)) u_pick (
        .req_i   (ready_w),
        .grant_o (grant_w),
        .idx_o   (idx_w),
        .any_o   (any_w)
    );

    // Pending bits: served bit drops, new events set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~grant_w) | fire_vec_i;
    end

    // Registered request output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else begin
            valid_q <= any_w;
            vec_q   <= idx_w;
        end
    end

    assign pending_o   = pend_q;
    assign irq_valid_o = valid_q;
    assign irq_vec_o   = vec_q;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vchk
        // A masked pending vector stays pending.
        p_hold_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[v] && vec_mask_i[v]) |=> pend_q[v]);

        // Every request came from a pending, unmasked vector one cycle earlier.
        p_req_from_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && vec_q == VEC_W'(v)) |-> $past(pend_q[v] && !vec_mask_i[v]));

        // Nothing lower than a served vector was left waiting unmasked.
        if (v > 0) begin : g_order
            p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_q && vec_q == VEC_W'(v)) |-> ($past(ready_w[v-1:0]) == '0));
        end
    end

endmodule

// File: rtl/credit_irq_moderator.sv
// Module: top of the credit-based interrupt moderator.
// Instantiates one credit tracker per ring, maps ring fire pulses onto
// vectors (0,1 direct, then ring+2) and feeds the vector dispatcher.
// Assumes the credit-return port addresses one ring per write.
module credit_irq_moderator #(
    parameter  int NUM_RINGS = 8,
    parameter  int CREDIT_W  = 16,
    localparam int NUM_VEC   = NUM_RINGS + 2,
    localparam int RING_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
    localparam int VEC_W     = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RINGS-1:0] cmpl_i,
    input  logic                 ret_we_i,
    input  logic [RING_W-1:0]    ret_ring_i,
    input  logic [CREDIT_W-1:0]  ret_cnt_i,
    input  logic [RING_W-1:0]    rd_ring_i,
    output logic [CREDIT_W-1:0]  rd_credit_o,
    input  logic [NUM_VEC-1:0]   vec_mask_i,
    output logic                 irq_valid_o,
    output logic [VEC_W-1:0]     irq_vec_o,
    output logic [NUM_VEC-1:0]   pending_o
);
    logic [CREDIT_W-1:0] credit_w [NUM_RINGS];
    logic [NUM_RINGS-1:0] fire_w;
    logic [NUM_RINGS-1:0] amask_w;
    logic [NUM_VEC-1:0]   fire_vec_w;

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        logic ret_hit;
        // Return write addressed to this ring.
        assign ret_hit = ret_we_i && (ret_ring_i == RING_W'(r));

        imod_ring_credit #(.CREDIT_W(CREDIT_W)) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmpl_i     (cmpl_i[r]),
            .ret_we_i   (ret_hit),
            .ret_cnt_i  (ret_cnt_i),
            .credit_o   (credit_w[r]),
            .automask_o (amask_w[r]),
            .fire_o     (fire_w[r])
        );
    end

    // Ring-to-vector routing of fire pulses.
    always_comb begin
        fire_vec_w = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            fire_vec_w[imod_pkg::ring_to_vec(r)] = fire_w[r];
        end
    end

    // Count read-back mux; out-of-range ring reads zero.
    always_comb begin
        rd_credit_o = '0;
        for (int r = 0; r < NUM_RINGS; r++) begin
            if (rd_ring_i == RING_W'(r)) rd_credit_o = credit_w[r];
        end
    end

    imod_vec_dispatch #(.NUM_VEC(NUM_VEC)) u_disp (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_vec_i  (fire_vec_w),
        .vec_mask_i  (vec_mask_i),
        .pending_o   (pending_o),
        .irq_valid_o (irq_valid_o),
        .irq_vec_o   (irq_vec_o)
    );

    // Reserved vectors never carry a request or a pending bit.
    if (NUM_VEC > 3) begin : g_rsv
        p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(irq_valid_o && (irq_vec_o == VEC_W'(2) || irq_vec_o == VEC_W'(3)))
            && !pending_o[2] && !pending_o[3]);
    end

    // Vector masking never disturbs ring state (moderation mask holds with idle inputs).
    p_vecmask_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i == '0 && !ret_we_i) |=> $stable(amask_w));

endmodule

// File: tb/credit_irq_moderator_tb.sv
// Bench: scoreboard of expected interrupt vectors, checked by a monitor.
module credit_irq_moderator_tb;
    localparam int NR = 8;
    localparam int CW = 4;
    localparam int NV = NR + 2;
    localparam int RW = 3;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] cmpl_i = '0;
    logic          ret_we_i = 1'b0;
    logic [RW-1:0] ret_ring_i = '0;
    logic [CW-1:0] ret_cnt_i = '0;
    logic [RW-1:0] rd_ring_i = '0;
    logic [CW-1:0] rd_credit_o;
    logic [NV-1:0] vec_mask_i = '0;
    logic          irq_valid_o;
    logic [VW-1:0] irq_vec_o;
    logic [NV-1:0] pending_o;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    int    exp_vec[$];
    string exp_tag[$];

    always #4 clk = ~clk;

    credit_irq_moderator #(.NUM_RINGS(NR), .CREDIT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .ret_we_i(ret_we_i),
        .ret_ring_i(ret_ring_i), .ret_cnt_i(ret_cnt_i), .rd_ring_i(rd_ring_i),
        .rd_credit_o(rd_credit_o), .vec_mask_i(vec_mask_i),
        .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o), .pending_o(pending_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: every request is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (rst_n && irq_valid_o && !done) begin
            chk(irq_vec_o != 2 && irq_vec_o != 3, "R8", "reserved vector requested", irq_vec_o, 0);
            if (exp_vec.size() == 0) begin
                chk(1'b0, "R3", "unexpected request", irq_vec_o, -1);
            end else begin
                automatic int    ev = exp_vec.pop_front();
                automatic string et = exp_tag.pop_front();
                chk(irq_vec_o == VW'(ev), et, "request vector", irq_vec_o, ev);
            end
        end
    end

    task automatic expect_vec(input int v, input string tag);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        chk(exp_vec.size() == 0, tag, "missing requests", exp_vec.size(), 0);
        exp_vec.delete();
        exp_tag.delete();
    endtask

    task automatic cmpl(input int r);
        @(negedge clk);
        cmpl_i[r] = 1'b1;
        @(negedge clk);
        cmpl_i = '0;
    endtask

    task automatic give_back(input int r, input int n);
        @(negedge clk);
        ret_we_i = 1'b1; ret_ring_i = RW'(r); ret_cnt_i = CW'(n);
        @(negedge clk);
        ret_we_i = 1'b0;
    endtask

    task automatic both(input int r, input int n);
        @(negedge clk);
        cmpl_i[r] = 1'b1;
        ret_we_i = 1'b1; ret_ring_i = RW'(r); ret_cnt_i = CW'(n);
        @(negedge clk);
        cmpl_i = '0;
        ret_we_i = 1'b0;
    endtask

    task automatic check_credit(input int r, input int exp, input string tag);
        @(negedge clk);
        rd_ring_i = RW'(r);
        #1;
        chk(rd_credit_o == CW'(exp), tag, $sformatf("credit ring %0d", r), rd_credit_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(irq_valid_o == 1'b0, "R12", "valid after reset", irq_valid_o, 0);
        chk(pending_o == '0, "R12", "pending after reset", pending_o, 0);
        for (int r = 0; r < NR; r++) check_credit(r, 0, "R12");

        // R2, R8, R12: first completion on ring 2 -> vector 4, exact timing
        expect_vec(4, "R2");
        cmpl(2);
        chk(irq_valid_o == 1'b0 && pending_o[4], "R12", "pending before request",
            {irq_valid_o, pending_o[4]}, 1);
        @(negedge clk);
        chk(irq_valid_o == 1'b1, "R12", "request one cycle later", irq_valid_o, 1);
        settle("R2");
        check_credit(2, 1, "R1");

        // R3: further completions while moderated only count
        cmpl(2);
        cmpl(2);
        settle("R3");
        check_credit(2, 3, "R3");

        // R5: partial return re-interrupts
        expect_vec(4, "R5");
        give_back(2, 1);
        settle("R5");
        check_credit(2, 2, "R5");

        // R4: full return is silent, then re-armed
        give_back(2, 2);
        settle("R4");
        check_credit(2, 0, "R4");
        expect_vec(4, "R4");
        cmpl(2);
        settle("R4");
        give_back(2, 1);
        settle("R4");

        // R6: over-return clamps to zero and re-arms; ring 3 -> vector 5
        expect_vec(5, "R6");
        cmpl(3);
        settle("R6");
        give_back(3, 10);
        settle("R6");
        check_credit(3, 0, "R6");
        expect_vec(5, "R6");
        cmpl(3);
        settle("R6");
        give_back(3, 1);
        settle("R6");

        // R7: same-cycle completion and return on ring 0 (vector 0)
        expect_vec(0, "R7");
        cmpl(0);
        settle("R7");
        both(0, 2);
        settle("R7");
        check_credit(0, 0, "R7");
        expect_vec(0, "R7");
        cmpl(0);
        settle("R7");
        expect_vec(0, "R7");
        both(0, 1);
        settle("R7");
        check_credit(0, 1, "R7");
        both(0, 5);
        settle("R7");
        check_credit(0, 0, "R7");
        expect_vec(0, "R7");
        cmpl(0);
        settle("R7");
        give_back(0, 1);
        settle("R7");

        // R9, R10: vector 9 (ring 7) masked
        vec_mask_i[9] = 1'b1;
        cmpl(7);
        settle("R9");
        chk(pending_o[9] == 1'b1, "R9", "pending while masked", pending_o[9], 1);
        cmpl(7);
        settle("R10");
        check_credit(7, 2, "R10");
        expect_vec(9, "R9");
        @(negedge clk);
        vec_mask_i = '0;
        settle("R9");
        chk(pending_o[9] == 1'b0, "R9", "pending after delivery", pending_o[9], 0);
        check_credit(7, 2, "R10");
        give_back(7, 2);
        settle("R10");

        // R11, R8: vectors 1 and 6 (rings 1 and 4) released together
        @(negedge clk);
        vec_mask_i[1] = 1'b1;
        vec_mask_i[6] = 1'b1;
        @(negedge clk);
        cmpl_i[1] = 1'b1;
        cmpl_i[4] = 1'b1;
        @(negedge clk);
        cmpl_i = '0;
        settle("R11");
        chk(pending_o[1] && pending_o[6], "R11", "both pending", {pending_o[6], pending_o[1]}, 3);
        expect_vec(1, "R11");
        expect_vec(6, "R11");
        @(negedge clk);
        vec_mask_i = '0;
        settle("R11");
        give_back(1, 1);
        give_back(4, 1);
        settle("R11");
        chk(pending_o[2] == 1'b0 && pending_o[3] == 1'b0, "R8", "reserved pending",
            {pending_o[3], pending_o[2]}, 0);

        // R1: saturation at 15 on ring 5 (vector 7)
        expect_vec(7, "R1");
        for (int i = 0; i < 20; i++) cmpl(5);
        settle("R1");
        check_credit(5, 15, "R1");
        give_back(5, 15);
        settle("R1");
        check_credit(5, 0, "R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule